// File: doc/BRIEF.md
# Split-Register 14-bit Pulse-Width Modulator

This block turns a 14-bit duty word into a fixed-frequency pulse train on one output pin. Software loads the word through a byte-wide write port in two steps. First it writes the low eight bits into a holding register. Then it writes the six high bits, and that second write moves the whole word into a staged duty register. The waveform generator copies the staged value into its active compare register only when its period counter wraps. Every period is therefore generated from one consistent duty value.

A clock-select bit sets how fast the period counter steps. With the bit clear the counter advances on every system clock. With it set the counter advances on every second clock. The same bit therefore stretches the period and the step size together. The output rises at the start of each period and stays high for as many steps as the duty word holds. All registers are write-only: any read returns all ones.

Top module: `pwm14_split`

## Requirements
- R1: While `rd_en` is high, `rd_data` is 8'hFF at every address. While `rd_en` is low, `rd_data` is 8'h00.
- R2: After reset the output is low, the staged and active duty values are zero and the clock select is 0. The output therefore stays low through the first two periods unless a high-part write occurs.
- R3: A write to address 1 (low byte) only updates the holding register. It changes neither the staged value nor the output.
- R4: A write to address 2 (high part) stages `{wdata[5:0], holding}` as the 14-bit duty. The output uses the new value from the next period start onward.
- R5: With clock select 0, a period lasts 16384 clocks and the output is high for exactly duty clocks.
- R6: Bit 0 of a write to address 0 sets the clock select. With it at 1 a period lasts 32768 clocks and the output is high for 2×duty clocks. Step boundaries are realigned at every period start.
- R7: The output rises only at a period start. A duty of 0 keeps it low for the whole period. A duty of 16383 leaves it low only during the final step.
- R8: A high-part write sampled on the same clock edge as a period wrap misses that wrap. The period that follows still uses the old duty, and the new value applies one period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register select: 0 control, 1 duty low byte, 2 duty high part |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data (all ones while reading) |
| pwm_out | output | 1 | Pulse-width modulated output |

## Verification
Two events can fall in the same cycle: a high-part transfer into the staged register and the period wrap that copies the staged value into the active compare register. The bench follows the period position with its own model. It drives the high-part write so that the write is sampled exactly on the wrap edge. It then measures the high time of the next two periods. The first must still show the old duty and the second the new one. The bench uses the same edge to switch the clock select, and the following period must be exactly 32768 clocks long with twice the step width.

// File: rtl/pwm14_pkg.sv
package pwm14_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL    = 2'd0,
        REG_DUTY_LO = 2'd1,
        REG_DUTY_HI = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/pwm14_regs.sv
module pwm14_regs
    import pwm14_pkg::*;
#(
    parameter int DUTY_W = 14,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [DUTY_W-1:0] staged_o,
    output logic              sel_o
);
    localparam int HI_W = DUTY_W - BUS_W;

    typedef struct packed {
        logic [BUS_W-1:0]  hold;
        logic [DUTY_W-1:0] staged;
        logic              sel;
    } regs_s;

    regs_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                REG_CTRL:    r_d.sel    = wdata[0];
                REG_DUTY_LO: r_d.hold   = wdata;
                REG_DUTY_HI: r_d.staged = {wdata[HI_W-1:0], r_q.hold};
                default:     r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign staged_o = r_q.staged;
    assign sel_o    = r_q.sel;

    // R3: a low-byte write leaves the staged duty untouched
    a_r3_low_keeps_staged: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DUTY_LO) |=> $stable(r_q.staged));

    // R4: a high-part write stages the combined word
    a_r4_high_stages_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DUTY_HI) |=>
            (r_q.staged == {$past(wdata[HI_W-1:0]), $past(r_q.hold)}));
endmodule

// File: rtl/pwm14_prescale.sv
module pwm14_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic wrap_i,
    output logic step_o
);
    logic ph_d, ph_q;

    always_comb begin
        ph_d = wrap_i ? 1'b0 : ~ph_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ph_d;
    end

    assign step_o = !sel_i || ph_q;

    // R6: with the slow clock selected, steps are never on adjacent cycles
    a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && step_o) |=> (!step_o || !sel_i));
endmodule

// File: rtl/pwm14_gen.sv
module pwm14_gen #(
    parameter int DUTY_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [DUTY_W-1:0] staged_i,
    output logic              wrap_o,
    output logic              pwm_o
);
    localparam logic [DUTY_W-1:0] CNT_MAX = {DUTY_W{1'b1}};

    typedef struct packed {
        logic [DUTY_W-1:0] cnt;
        logic [DUTY_W-1:0] active;
        logic              out;
    } gen_s;

    gen_s g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (step_i) begin
            if (g_q.cnt == CNT_MAX) begin
                g_d.cnt    = '0;
                g_d.active = staged_i;
            end else begin
                g_d.cnt = g_q.cnt + 1'b1;
            end
        end
        g_d.out = (g_d.cnt < g_d.active);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign wrap_o = step_i && (g_q.cnt == CNT_MAX);
    assign pwm_o  = g_q.out;

    // R5: the counter advances by exactly one on a non-wrapping step
    a_r5_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && g_q.cnt != CNT_MAX) |=> (g_q.cnt == DUTY_W'($past(g_q.cnt) + 1'b1)));

    // R8: the active duty only changes as a new period begins
    a_r8_active_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(g_q.active) |-> (g_q.cnt == '0));

    // R7: the output only rises at a period start
    a_r7_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_q.out) |-> (g_q.cnt == '0));
endmodule

// File: rtl/pwm14_split.sv
module pwm14_split
    import pwm14_pkg::*;
#(
    parameter int DUTY_W = 14,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rd_data,
    output logic              pwm_out
);
    logic [DUTY_W-1:0] staged;
    logic              sel;
    logic              step;
    logic              wrap;

    pwm14_regs #(.DUTY_W(DUTY_W), .BUS_W(BUS_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .staged_o (staged),
        .sel_o    (sel)
    );

    pwm14_prescale u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .wrap_i (wrap),
        .step_o (step)
    );

    pwm14_gen #(.DUTY_W(DUTY_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .staged_i (staged),
        .wrap_o   (wrap),
        .pwm_o    (pwm_out)
    );

    // R1: write-only registers read back as all ones
    assign rd_data = rd_en ? {BUS_W{1'b1}} : '0;
endmodule

// File: tb/pwm14_split_bench.sv
module pwm14_split_bench;
    localparam int MAXC = 16383;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rd_data;
    logic       pwm_out;

    int checks = 0;
    int fails = 0;
    int mism = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pwm14_split u_pwm14_split (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    // behavioural reference: position in period, staged and active duty
    int   m_cnt, m_act, m_staged, m_hold;
    bit   m_sel, m_ph, m_wrapped;
    logic m_step;
    assign m_step = !m_sel || m_ph;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_act <= 0; m_staged <= 0; m_hold <= 0;
            m_sel <= 0; m_ph <= 0; m_wrapped <= 0;
        end else begin
            m_wrapped <= 0;
            if (m_step && m_cnt == MAXC) begin
                m_cnt <= 0; m_act <= m_staged; m_ph <= 0; m_wrapped <= 1;
            end else begin
                if (m_step) m_cnt <= m_cnt + 1;
                m_ph <= !m_ph;
            end
            if (wr_en) begin
                if (addr == 2'd0) m_sel <= wdata[0];
                if (addr == 2'd1) m_hold <= wdata;
                if (addr == 2'd2) m_staged <= (int'(wdata[5:0]) * 256) + m_hold;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished && (pwm_out !== (m_cnt < m_act))) mism++;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_check(input logic [1:0] a, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 check(tag, int'(rd_data), 255);
        rd_en = 1'b0;
    endtask

    // entered at the negedge just after a wrap; returns at the next one
    task automatic measure(input int nw,
                           input logic [1:0] a0, input logic [7:0] d0,
                           input logic [1:0] a1, input logic [7:0] d1,
                           input bit late, input logic [1:0] la, input logic [7:0] ld,
                           output int hi, output int len);
        hi = 0; len = 0;
        forever begin
            hi += int'(pwm_out);
            len++;
            wr_en = 1'b0;
            if (late && m_cnt == MAXC && !m_sel) begin
                wr_en = 1'b1; addr = la; wdata = ld;
            end else if (len == 1 && nw > 0) begin
                wr_en = 1'b1; addr = a0; wdata = d0;
            end else if (len == 2 && nw > 1) begin
                wr_en = 1'b1; addr = a1; wdata = d1;
            end
            @(negedge clk);
            if (m_wrapped) break;
        end
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        int hi, len;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset output low", int'(pwm_out), 0);
        read_check(2'd0, "R1 read ctrl");
        read_check(2'd1, "R1 read duty low");
        read_check(2'd2, "R1 read duty high");
        read_check(2'd3, "R1 read unused");
        #1 check("R1 idle read zero", int'(rd_data), 0);
        bus_write(2'd1, 8'h34);
        while (!m_wrapped) @(negedge clk);

        // P1: only a low byte was written, duty still zero; stage 0x1234
        measure(1, 2'd2, 8'h12, 2'd0, 8'h00, 0, 2'd0, 8'h00, hi, len);
        check("R3 low-only write no effect hi", hi, 0);
        check("R5 period length sel0", len, 16384);
        // P2: 0x1234 active; low byte only
        measure(1, 2'd1, 8'hFF, 2'd0, 8'h00, 0, 2'd0, 8'h00, hi, len);
        check("R4 duty 0x1234 hi", hi, 4660);
        // P3: low write ignored, still 0x1234; stage 0x3FFF
        measure(1, 2'd2, 8'h3F, 2'd0, 8'h00, 0, 2'd0, 8'h00, hi, len);
        check("R3 low write not transferred hi", hi, 4660);
        // P4: full-scale duty; high write lands on the wrap edge
        measure(1, 2'd1, 8'h00, 2'd0, 8'h00, 1, 2'd2, 8'h01, hi, len);
        check("R7 full scale hi", hi, 16383);
        check("R5 full scale period", len, 16384);
        // P5: the wrap-edge transfer missed this period
        measure(0, 2'd0, 8'h00, 2'd0, 8'h00, 0, 2'd0, 8'h00, hi, len);
        check("R8 same-edge transfer deferred hi", hi, 16383);
        // P6: 0x0100 now active; stage 0x1000, switch clock on the last cycle
        measure(1, 2'd2, 8'h10, 2'd0, 8'h00, 1, 2'd0, 8'h01, hi, len);
        check("R8 deferred value applied hi", hi, 256);
        check("R5 period before clock switch", len, 16384);
        // P7: slow clock, duty 0x1000
        measure(0, 2'd0, 8'h00, 2'd0, 8'h00, 0, 2'd0, 8'h00, hi, len);
        check("R6 sel1 hi", hi, 8192);
        check("R6 sel1 period", len, 32768);
        check("R7 per-clock model mismatches", mism, 0);
        summary();
    end
endmodule